// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static memory in which every command is accepted in one clock. The commands are load-read, load-write, deselect and burst-continue. All of them share the same fixed latency: the data transfer for a command takes place on the second active clock edge after the edge that accepted it. Because reads and writes wait the same number of cycles, a write can directly follow a read, and a read can directly follow a write, with no idle cycle between them on the data buses.

The data path uses two buses. The data-in bus `wdata` is captured for writes. The data-out bus `rdata` comes with a flag `rvalid` that marks the cycles in which the memory would drive its pins. Each write can update only some of the 9-bit byte lanes. A four-beat burst can be started from one address, in either a wrapping-increment order or an XOR order. A clock-enable input freezes the whole pipeline. A sleep input freezes it as well and also releases the outputs, and the output enable releases the outputs at once.

Top module: `zt_sram`

## Requirements
- R1: A load with `load_n`=0, chips selected and `rd_wr`=1 is a read. After the second active edge that follows it, `rvalid`=1 and `rdata` holds the stored word. Both hold for one cycle, unless the next command is also a read.
- R2: A load with `rd_wr`=0 is a write. `wdata` is captured on the second active edge after the command. Read and write commands may alternate on consecutive edges with no idle cycle.
- R3: Bit k of `bwe_n`, active low, enables byte lane k, which is `wdata[9k+8:9k]`. Only enabled lanes are written. `bwe_n` is sampled on every write command, including burst-continue cycles, and is ignored for reads.
- R4: A read issued right after a write to the same address returns the newly written lanes, merged with the old contents of the disabled lanes.
- R5: A load with `cs1_n`=1, `cs2`=0 or `cs3_n`=1 is a deselect. It transfers nothing and leaves `rvalid`=0 two active edges later. It also ends any burst, so a following `load_n`=1 does nothing.
- R6: `load_n`=1 continues the current burst. `addr` is ignored and the read/write type of the burst is kept. The low two address bits step through base+1, base+2, base+3 modulo 4 when `burst_ilv`=0, and through base XOR 1, XOR 2, XOR 3 when `burst_ilv`=1. The upper address bits stay fixed.
- R7: With `cke_n`=1 at an edge, no pipeline stage, burst state or array word changes, and `rvalid` and `rdata` keep their values.
- R8: `oe_n`=1 forces `rvalid`=0 and `rdata`=0 at once, without waiting for a clock edge. Lowering it restores the pending output.
- R9: `sleep`=1 freezes every stage as in R7, ignores commands, forces `rvalid`=0 and `rdata`=0, and keeps the array contents.
- R10: During and after reset the pipeline holds no command, `rvalid`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls everything |
| sleep | input | 1 | Power-down request; freezes state and releases outputs |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 loads a new command, 1 continues the burst |
| rd_wr | input | 1 | 1 read, 0 write (load cycles only) |
| addr | input | ADDR_W | Word address |
| bwe_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | LANES*LANE_W | Write data, captured two active edges after the command |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rvalid | output | 1 | Read data is being driven |

## Verification
The hardest case is a read that is already held inside the pipeline when the clock enable goes high. From the ports alone it must be shown that the stall edges do not count toward the two-edge latency and that the read data stays put during a stall. The stimulus table issues a read and holds `cke_n` high for the next two edges while driving a write command on the other inputs. It then expects the data only after the second active edge and holds `cke_n` high once more while the word is on the bus. A merged byte-lane write followed at once by a read of the same word, and a burst-continue after a deselect, are also placed back to back in the table.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   // Burst address order selected by the static order input.
   typedef enum logic {
      ORD_WRAP_INC = 1'b0,
      ORD_XOR      = 1'b1
   } burst_ord_e;

endpackage

// File: rtl/zt_sram_burst.sv
module zt_sram_burst
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              sel,
   input  logic              rd_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  burst_ord_e        ord,
   output logic              live,
   output logic              rd,
   output logic [ADDR_W-1:0] nxt_addr
);

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] step;
   logic [BURST_W-1:0] lo;

   assign step = cnt_q + 1'b1;

   always_comb begin
      if (ord == ORD_XOR) lo = base_q[BURST_W-1:0] ^ step;
      else                lo = base_q[BURST_W-1:0] + step;
   end

   assign nxt_addr = {base_q[ADDR_W-1:BURST_W], lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live   <= 1'b0;
         rd     <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (en) begin
         if (load) begin
            live   <= sel;
            rd     <= rd_in;
            base_q <= addr_in;
            cnt_q  <= '0;
         end else if (live) begin
            cnt_q  <= step;
         end
      end
   end

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic [W-1:0] r;
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  r <= '0;
            else if (en) r <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  r <= '0;
            else if (en) r <= g_stg[s-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_n,
   input  logic [ADDR_W-1:0]       a,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && !lane_n[g]) mem[a] <= din[g*LANE_W +: LANE_W];
      end
      assign dout[g*LANE_W +: LANE_W] = mem[a];
   end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 2,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2,
   parameter int LATENCY = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    sleep,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    load_n,
   input  logic                    rd_wr,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        bwe_n,
   input  logic                    burst_ilv,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rvalid
);

   localparam int DATA_W = LANES * LANE_W;
   localparam int CMD_W  = 2 + ADDR_W + LANES;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("zt_sram: LANES and LANE_W must be at least 1");
   end
   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("zt_sram: BURST_W must lie in 1..ADDR_W-1");
   end
   if (LATENCY < 1) begin : g_bad_lat
      $error("zt_sram: LATENCY must be at least 1");
   end

   typedef struct packed {
      logic              vld;
      logic              rd;
      logic [ADDR_W-1:0] a;
      logic [LANES-1:0]  bw_n;
   } cmd_t;

   logic              act;
   logic              sel;
   logic              b_live;
   logic              b_rd;
   logic [ADDR_W-1:0] b_addr;
   cmd_t              cmd_in;
   logic [CMD_W-1:0]  ex_raw;
   cmd_t              ex;
   logic [DATA_W-1:0] arr_q;
   logic              drive_q;
   logic [DATA_W-1:0] dout_q;

   assign act = !cke_n && !sleep;
   assign sel = !cs1_n && cs2 && !cs3_n;

   zt_sram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (act),
      .load     (!load_n),
      .sel      (sel),
      .rd_in    (rd_wr),
      .addr_in  (addr),
      .ord      (burst_ord_e'(burst_ilv)),
      .live     (b_live),
      .rd       (b_rd),
      .nxt_addr (b_addr)
   );

   // Command formed at the input edge: a fresh load or the next burst beat.
   always_comb begin
      cmd_in = '0;
      if (!load_n) begin
         if (sel) begin
            cmd_in.vld  = 1'b1;
            cmd_in.rd   = rd_wr;
            cmd_in.a    = addr;
            cmd_in.bw_n = rd_wr ? '1 : bwe_n;
         end
      end else if (b_live) begin
         cmd_in.vld  = 1'b1;
         cmd_in.rd   = b_rd;
         cmd_in.a    = b_addr;
         cmd_in.bw_n = b_rd ? '1 : bwe_n;
      end
   end

   zt_sram_pipe #(.W(CMD_W), .STAGES(LATENCY)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (act),
      .d     (cmd_in),
      .q     (ex_raw)
   );

   assign ex = ex_raw;

   // Commands execute in order, so a read always sees every earlier write.
   zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk    (clk),
      .we     (act && ex.vld && !ex.rd),
      .lane_n (ex.bw_n),
      .a      (ex.a),
      .din    (wdata),
      .dout   (arr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         dout_q  <= '0;
      end else if (act) begin
         drive_q <= ex.vld && ex.rd;
         if (ex.vld && ex.rd) dout_q <= arr_q;
      end
   end

   assign rvalid = drive_q && !oe_n && !sleep;
   assign rdata  = rvalid ? dout_q : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic cke_n,
   input logic sleep,
   input logic cs1_n,
   input logic cs2,
   input logic cs3_n,
   input logic load_n,
   input logic oe_n,
   input logic rvalid
);

   logic live_edge;
   logic desel_cmd;

   assign live_edge = !cke_n && !sleep;
   assign desel_cmd = live_edge && !load_n && (cs1_n || !cs2 || cs3_n);

   // R8: output enable high leaves the bus undriven
   assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rvalid);

   // R9: sleep releases the bus
   assert_sleep_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rvalid);

   // R7: a stalled edge leaves the output flag unchanged
   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_n && !sleep) |=>
         (rvalid == $past(rvalid)) || (oe_n != $past(oe_n)) || (sleep != $past(sleep)));

   // R5: two active edges after a deselect, nothing is driven
   assert_desel_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(desel_cmd, 3) && $past(live_edge, 2) && $past(live_edge, 1)) |-> !rvalid);

   // R10: nothing is driven while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R10: assert (!rvalid);
      end
   end

endmodule

bind zt_sram zt_sram_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cke_n  (cke_n),
   .sleep  (sleep),
   .cs1_n  (cs1_n),
   .cs2    (cs2),
   .cs3_n  (cs3_n),
   .load_n (load_n),
   .oe_n   (oe_n),
   .rvalid (rvalid)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;

   logic        clk = 1'b0;
   logic        rst_n, cke_n, sleep, cs1_n, cs2, cs3_n, load_n, rd_wr;
   logic [5:0]  addr;
   logic [1:0]  bwe_n;
   logic        burst_ilv, oe_n;
   logic [17:0] wdata, rdata;
   logic        rvalid;
   int          checks = 0;
   int          fails  = 0;

   always #4 clk = ~clk;

   zt_sram uut (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .load_n(load_n),
      .rd_wr(rd_wr), .addr(addr), .bwe_n(bwe_n), .burst_ilv(burst_ilv),
      .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
   );

   typedef struct packed {
      logic        ld_n;
      logic        rd;
      logic        ck_n;
      logic        dsl;
      logic [1:0]  bw;
      logic [5:0]  a;
      logic [17:0] wd;
      logic        ev;
      logic [17:0] ed;
   } vec_t;

   localparam int NV = 29;
   // wd on step i feeds the write of step i-2; ev/ed show the read of step i-2.
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd4 ,18'h00000,1'b0,18'h00000}, //  0 write A4
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd5 ,18'h00000,1'b0,18'h00000}, //  1 write A5
      '{1'b0,1'b1,1'b0,1'b0,2'b00,6'd4 ,18'h12345,1'b0,18'h00000}, //  2 read A4, R2
      '{1'b0,1'b1,1'b0,1'b0,2'b00,6'd5 ,18'h0ABCD,1'b0,18'h00000}, //  3 read A5
      '{1'b0,1'b0,1'b0,1'b0,2'b10,6'd4 ,18'h00000,1'b1,18'h12345}, //  4 write A4 lane0 only, R3
      '{1'b0,1'b1,1'b0,1'b0,2'b00,6'd4 ,18'h00000,1'b1,18'h0ABCD}, //  5 read A4, R4
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h3FFFF,1'b0,18'h00000}, //  6 deselect
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b1,18'h123FF}, //  7 merged word, R4
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b0,18'h00000}, //  8
      '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd8 ,18'h00000,1'b0,18'h00000}, //  9 burst write A8, R6
      '{1'b1,1'b0,1'b0,1'b0,2'b00,6'h3F,18'h00000,1'b0,18'h00000}, // 10 advance
      '{1'b1,1'b0,1'b0,1'b0,2'b00,6'h3F,18'h00001,1'b0,18'h00000}, // 11
      '{1'b1,1'b0,1'b0,1'b0,2'b00,6'h3F,18'h00002,1'b0,18'h00000}, // 12
      '{1'b0,1'b1,1'b0,1'b0,2'b00,6'd10,18'h00003,1'b0,18'h00000}, // 13 burst read A10
      '{1'b1,1'b0,1'b0,1'b0,2'b00,6'h3F,18'h00004,1'b0,18'h00000}, // 14
      '{1'b1,1'b0,1'b0,1'b0,2'b11,6'h3F,18'h00000,1'b1,18'h00003}, // 15 A10
      '{1'b1,1'b0,1'b0,1'b0,2'b00,6'h3F,18'h00000,1'b1,18'h00004}, // 16 A11
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b1,18'h00001}, // 17 A8 wrap
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b1,18'h00002}, // 18 A9
      '{1'b1,1'b1,1'b0,1'b0,2'b00,6'h3F,18'h00000,1'b0,18'h00000}, // 19 advance after deselect, R5
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b0,18'h00000}, // 20
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b0,18'h00000}, // 21 step 19 did nothing
      '{1'b0,1'b1,1'b0,1'b0,2'b00,6'd11,18'h00000,1'b0,18'h00000}, // 22 read A11
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'h3F,18'h3FFFF,1'b0,18'h00000}, // 23 stall, R7
      '{1'b0,1'b0,1'b1,1'b0,2'b00,6'h3F,18'h3FFFF,1'b0,18'h00000}, // 24 stall
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b0,18'h00000}, // 25
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b1,18'h00004}, // 26 read A11 out
      '{1'b0,1'b0,1'b1,1'b1,2'b00,6'd0 ,18'h00000,1'b1,18'h00004}, // 27 stall holds
      '{1'b0,1'b0,1'b0,1'b1,2'b00,6'd0 ,18'h00000,1'b0,18'h00000}  // 28
   };

   task automatic chk(input string tag, input logic ev, input logic [17:0] ed);
      logic [17:0] exp_d;
      exp_d = ev ? ed : 18'h0;
      checks++;
      if (rvalid !== ev || rdata !== exp_d) begin
         fails++;
         $display("FAIL %s: actual rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                  tag, rvalid, rdata, ev, exp_d);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put(input logic ld, input logic rd, input logic ck,
                      input logic c1, input logic c2, input logic c3,
                      input logic [5:0] a, input logic [1:0] bw, input logic [17:0] wd);
      load_n = ld; rd_wr = rd; cke_n = ck;
      cs1_n = c1; cs2 = c2; cs3_n = c3;
      addr = a; bwe_n = bw; wdata = wd;
      tick();
   endtask

   task automatic idle(input logic [17:0] wd);
      put(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0, 2'b00, wd);
   endtask

   task automatic rd_word(input logic [5:0] a);
      put(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, a, 2'b00, 18'h0);
      idle(18'h0);
      idle(18'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (R1): actual=timeout expected=end of tests");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cke_n = 1'b0; sleep = 1'b0; oe_n = 1'b0; burst_ilv = 1'b0;
      cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0; load_n = 1'b0; rd_wr = 1'b0;
      addr = '0; bwe_n = '0; wdata = '0;
      repeat (3) @(negedge clk);
      chk("R10 idle during reset", 1'b0, 18'h0);
      rst_n = 1'b1;
      tick();
      chk("R10 idle after reset", 1'b0, 18'h0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VEC[i];
         load_n = v.ld_n; rd_wr = v.rd; cke_n = v.ck_n;
         cs1_n = v.dsl; cs2 = 1'b1; cs3_n = 1'b0;
         addr = v.a; bwe_n = v.bw; wdata = v.wd;
         tick();
         chk($sformatf("R1 R2 R3 R4 R5 R6 R7 table step %0d", i), v.ev, v.ed);
      end

      // R6: XOR order from base 9 visits 9, 8, 11, 10
      burst_ilv = 1'b1;
      put(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd9, 2'b00, 18'h0);
      put(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h3F, 2'b00, 18'h0);
      put(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h3F, 2'b00, 18'h0);
      chk("R6 xor beat 0", 1'b1, 18'h00002);
      put(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h3F, 2'b00, 18'h0);
      chk("R6 xor beat 1", 1'b1, 18'h00001);
      idle(18'h0);
      chk("R6 xor beat 2", 1'b1, 18'h00004);
      idle(18'h0);
      chk("R6 xor beat 3", 1'b1, 18'h00003);
      idle(18'h0);
      chk("R6 burst ended", 1'b0, 18'h0);
      burst_ilv = 1'b0;

      // R8: output enable acts without a clock edge
      rd_word(6'd5);
      oe_n = 1'b1; #1;
      chk("R8 oe high releases", 1'b0, 18'h0);
      oe_n = 1'b0; #1;
      chk("R8 oe low restores", 1'b1, 18'h0ABCD);

      // R5: writes with cs2 low or cs3_n high are deselects
      put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 2'b00, 18'h0);
      idle(18'h0);
      idle(18'h3FFFF);
      rd_word(6'd5);
      chk("R5 cs2 low write ignored", 1'b1, 18'h0ABCD);
      put(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd4, 2'b00, 18'h0);
      idle(18'h0);
      idle(18'h00000);
      rd_word(6'd4);
      chk("R5 cs3_n high write ignored", 1'b1, 18'h123FF);

      // R9: sleep releases outputs, ignores commands, keeps contents
      sleep = 1'b1; #1;
      chk("R9 sleep releases", 1'b0, 18'h0);
      put(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd4, 2'b00, 18'h0);
      chk("R9 asleep 1", 1'b0, 18'h0);
      idle(18'h0);
      idle(18'h0);
      chk("R9 asleep 2", 1'b0, 18'h0);
      sleep = 1'b0;
      idle(18'h0);
      idle(18'h0);
      rd_word(6'd4);
      chk("R9 contents kept, sleeping write ignored", 1'b1, 18'h123FF);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule